// File: doc/BRIEF.md
# Wait-for-Event Sleep Controller

This block decides when a small processor core may stop for a wait-for-event (WFE) or wait-for-interrupt (WFI) hint, and when it must resume. It holds a single sticky event bit. A send-event instruction, an external event pulse, or a newly pending interrupt line sets the bit when pend-to-event is enabled. Only a WFE that finds the bit set clears it. A WFE that finds the bit clear puts the core to sleep until the bit is set again. A WFI returns at once if any interrupt line is pending, and otherwise sleeps until one is.

The pending inputs are raw request levels, taken before any enable or global mask. Masking therefore has no effect on waking: a masked interrupt still ends WFI sleep, and its rising edge still counts as an event. The core stalls while `sleep_req_o` is high. It treats the cycle in which `hint_done_o` is high as the point where the hint instruction retires.

Top module: `hint_sleep_ctrl`

## Requirements
- R1: In the idle state, a WFE that finds the event bit set raises `hint_done_o` in that same cycle. No sleep follows, and the event bit reads 0 from the next cycle, unless a new event arrives in that cycle.
- R2: In the idle state, a WFE that finds the event bit clear keeps `hint_done_o` low and raises `sleep_req_o` from the next cycle.
- R3: Only WFE consumption clears the event bit. A pending line falling back to 0, or any other input activity, leaves a set bit at 1.
- R4: When `sev_on_pend_i` is 1, any line of `irq_pend_i` going from 0 to 1 sets the event bit, which reads 1 in the next cycle. When it is 0, pending edges do not touch the bit. Directly after reset every line is taken to have been 0 before.
- R5: A line that stays pending sets the bit only once. After a WFE clears the bit, the bit stays 0 while the line holds at 1.
- R6: A pulse on `sev_i` or on `ext_evt_i` sets the event bit from the next cycle. When a set and a WFE clear fall in the same cycle, the bit stays 1.
- R7: During WFE sleep, the first cycle in which the event bit reads 1 raises `hint_done_o`. In the next cycle `sleep_req_o` is 0 and the event bit has been consumed.
- R8: In the idle state, a WFI with any pending line raises `hint_done_o` at once and does not sleep. With no line pending it sleeps from the next cycle. It wakes, with `hint_done_o` high, in the first cycle that any line is pending, and `sleep_req_o` drops in the next cycle. WFI never changes the event bit.
- R9: After an earlier event, a first WFE returns at once. A second WFE with no new event between the two goes to sleep.
- R10: A synchronous active-high `rst` leaves the event bit at 0, `sleep_req_o` at 0 and the controller idle.
- R11: Hint strobes that arrive while asleep are ignored. When WFE and WFI arrive together in the idle state, the WFE is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wfe_i | input | 1 | WFE hint strobe from the core |
| wfi_i | input | 1 | WFI hint strobe from the core |
| sev_i | input | 1 | Send-event instruction strobe |
| ext_evt_i | input | 1 | External event pulse |
| sev_on_pend_i | input | 1 | Enables pending-edge events |
| irq_pend_i | input | NUM_IRQ | Raw per-line interrupt pending levels |
| sleep_req_o | output | 1 | Request to the core to sleep |
| hint_done_o | output | 1 | Hint instruction retires this cycle |
| evt_latch_o | output | 1 | Current value of the event bit |

## Verification
The bench builds the controller with NUM_IRQ set to 3. With that setting it can sweep all eight pending patterns, with pend-to-event both on and off, and it can wake WFI sleep from each line in turn. The event bit is set up before each WFE, so both the immediate-return path and the sleep path are reached. The set/clear collisions and the strobes that arrive during sleep are driven in exact cycles.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WFE   = 2'd1,
    ST_WFI   = 2'd2
  } hsc_state_e;

  // next value of the sticky event bit: a set beats a same-cycle consume
  function automatic logic evt_next(input logic set, input logic held, input logic consume);
    return set | (held & ~consume);
  endfunction

  function automatic logic is_asleep(input hsc_state_e st);
    return st != ST_IDLE;
  endfunction

endpackage

// File: rtl/hsc_pend_edge.sv
module hsc_pend_edge #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_i,
  output logic [NUM_IRQ-1:0] rise_o,
  output logic               any_o
);

  logic [NUM_IRQ-1:0] prev_q;

  generate
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) prev_q[gi] <= 1'b0;
        else     prev_q[gi] <= pend_i[gi];
      end
      assign rise_o[gi] = pend_i[gi] & ~prev_q[gi];
    end
  endgenerate

  assign any_o = |pend_i;

endmodule

// File: rtl/hsc_event_latch.sv
module hsc_event_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic consume_i,
  output logic q_o
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= hsc_pkg::evt_next(set_i, held_q, consume_i);
  end

  assign q_o = held_q;

endmodule

// File: rtl/hsc_sleep_fsm.sv
module hsc_sleep_fsm
  import hsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wfe_i,
  input  logic wfi_i,
  input  logic latch_i,
  input  logic any_pend_i,
  output logic sleep_req_o,
  output logic done_o,
  output logic consume_o
);

  hsc_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    done_o    = 1'b0;
    consume_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wfe_i) begin
          if (latch_i) begin
            done_o    = 1'b1;
            consume_o = 1'b1;
          end else begin
            state_d = ST_WFE;
          end
        end else if (wfi_i) begin
          if (any_pend_i) done_o = 1'b1;
          else            state_d = ST_WFI;
        end
      end
      ST_WFE: begin
        if (latch_i) begin
          done_o    = 1'b1;
          consume_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WFI: begin
        if (any_pend_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign sleep_req_o = is_asleep(state_q);

endmodule

// File: rtl/hint_sleep_ctrl.sv
module hint_sleep_ctrl #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wfe_i,
  input  logic               wfi_i,
  input  logic               sev_i,
  input  logic               ext_evt_i,
  input  logic               sev_on_pend_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  output logic               sleep_req_o,
  output logic               hint_done_o,
  output logic               evt_latch_o
);

  // named internal events, observed by the bound checker
  logic [NUM_IRQ-1:0] pend_rise_w;
  logic               pend_any_w;
  logic               evt_set_w;
  logic               evt_consume_w;

  hsc_pend_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pend_i (irq_pend_i),
    .rise_o (pend_rise_w),
    .any_o  (pend_any_w)
  );

  assign evt_set_w = sev_i | ext_evt_i | (sev_on_pend_i & (|pend_rise_w));

  hsc_event_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .set_i     (evt_set_w),
    .consume_i (evt_consume_w),
    .q_o       (evt_latch_o)
  );

  hsc_sleep_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wfe_i       (wfe_i),
    .wfi_i       (wfi_i),
    .latch_i     (evt_latch_o),
    .any_pend_i  (pend_any_w),
    .sleep_req_o (sleep_req_o),
    .done_o      (hint_done_o),
    .consume_o   (evt_consume_w)
  );

endmodule

// File: rtl/hint_sleep_ctrl_chk.sv
module hint_sleep_ctrl_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wfe_i,
  input logic               wfi_i,
  input logic [NUM_IRQ-1:0] irq_pend_i,
  input logic               sev_on_pend_i,
  input logic [NUM_IRQ-1:0] pend_rise_w,
  input logic               evt_set_w,
  input logic               evt_consume_w,
  input logic               sleep_req_o,
  input logic               hint_done_o,
  input logic               evt_latch_o
);

  p_hit_returns_r1: assert property (@(posedge clk) disable iff (rst)
    (!sleep_req_o && wfe_i && evt_latch_o) |-> hint_done_o);

  p_hit_no_sleep_r1: assert property (@(posedge clk) disable iff (rst)
    (!sleep_req_o && wfe_i && evt_latch_o) |=> !sleep_req_o);

  p_miss_sleeps_r2: assert property (@(posedge clk) disable iff (rst)
    (!sleep_req_o && wfe_i && !evt_latch_o) |=> sleep_req_o);

  p_clear_by_wfe_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(evt_latch_o) |-> $past(evt_consume_w));

  p_pend_edge_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (sev_on_pend_i && (|pend_rise_w)) |=> evt_latch_o);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    evt_set_w |=> evt_latch_o);

  p_wake_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (sleep_req_o && hint_done_o) |=> !sleep_req_o);

  p_wfi_sleeps_r8: assert property (@(posedge clk) disable iff (rst)
    (!sleep_req_o && !wfe_i && wfi_i && !(|irq_pend_i)) |=> sleep_req_o);

  p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sleep_req_o && !evt_latch_o));

endmodule

bind hint_sleep_ctrl hint_sleep_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wfe_i         (wfe_i),
  .wfi_i         (wfi_i),
  .irq_pend_i    (irq_pend_i),
  .sev_on_pend_i (sev_on_pend_i),
  .pend_rise_w   (pend_rise_w),
  .evt_set_w     (evt_set_w),
  .evt_consume_w (evt_consume_w),
  .sleep_req_o   (sleep_req_o),
  .hint_done_o   (hint_done_o),
  .evt_latch_o   (evt_latch_o)
);

// File: tb/hint_sleep_ctrl_tb.sv
module hint_sleep_ctrl_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfe_i = 1'b0, wfi_i = 1'b0, sev_i = 1'b0, ext_evt_i = 1'b0, sev_on_pend_i = 1'b0;
  logic [N-1:0] irq_pend_i = '0;
  logic sleep_req_o, hint_done_o, evt_latch_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hint_sleep_ctrl #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst(rst), .wfe_i(wfe_i), .wfi_i(wfi_i), .sev_i(sev_i),
    .ext_evt_i(ext_evt_i), .sev_on_pend_i(sev_on_pend_i), .irq_pend_i(irq_pend_i),
    .sleep_req_o(sleep_req_o), .hint_done_o(hint_done_o), .evt_latch_o(evt_latch_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // consume a held event with a one-cycle WFE (idle, bit set)
  task automatic drain();
    if (evt_latch_o) begin
      wfe_i = 1'b1;
      tick();
      wfe_i = 1'b0;
    end
  endtask

  task automatic pulse_sev();
    sev_i = 1'b1;
    tick();
    sev_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    #1;
    check("R10 sleep_req after reset", sleep_req_o, 1'b0);
    check("R10 event bit after reset", evt_latch_o, 1'b0);
    check("R10 done after reset", hint_done_o, 1'b0);
    tick();

    // R6 send-event, then R1 consume
    pulse_sev();
    check("R6 sev sets bit", evt_latch_o, 1'b1);
    wfe_i = 1'b1; #1;
    check("R1 WFE hit done", hint_done_o, 1'b1);
    tick(); wfe_i = 1'b0;
    check("R1 bit cleared", evt_latch_o, 1'b0);
    check("R1 no sleep", sleep_req_o, 1'b0);

    // R6 external event
    ext_evt_i = 1'b1; tick(); ext_evt_i = 1'b0;
    check("R6 ext sets bit", evt_latch_o, 1'b1);
    // R6 set beats same-cycle consume
    wfe_i = 1'b1; sev_i = 1'b1; #1;
    check("R6 collide done", hint_done_o, 1'b1);
    tick(); wfe_i = 1'b0; sev_i = 1'b0;
    check("R6 set wins", evt_latch_o, 1'b1);
    check("R6 collide no sleep", sleep_req_o, 1'b0);

    // R9 double WFE: first returns (bit set now), second sleeps
    wfe_i = 1'b1; #1;
    check("R9 first WFE returns", hint_done_o, 1'b1);
    tick(); wfe_i = 1'b0;
    wfe_i = 1'b1; #1;
    check("R9 second WFE no done", hint_done_o, 1'b0);
    tick(); wfe_i = 1'b0;
    check("R9 R2 second WFE sleeps", sleep_req_o, 1'b1);
    // R11 hints while asleep ignored
    wfi_i = 1'b1; wfe_i = 1'b1; #1;
    check("R11 hint ignored asleep", hint_done_o, 1'b0);
    tick(); wfi_i = 1'b0; wfe_i = 1'b0;
    check("R11 still asleep", sleep_req_o, 1'b1);
    tick();
    check("R7 stays asleep", sleep_req_o, 1'b1);
    // R7 wake on external event
    ext_evt_i = 1'b1; tick(); ext_evt_i = 1'b0; #1;
    check("R7 wake done", hint_done_o, 1'b1);
    check("R7 still asleep in wake cycle", sleep_req_o, 1'b1);
    tick();
    check("R7 sleep drops", sleep_req_o, 1'b0);
    check("R7 bit consumed", evt_latch_o, 1'b0);

    // R4 sweep of pending patterns and enable
    for (int s = 0; s < 2; s++) begin
      for (int pat = 0; pat < (1 << N); pat++) begin
        sev_on_pend_i = s[0];
        irq_pend_i = pat[N-1:0];
        tick();
        check($sformatf("R4 s=%0d pat=%0d", s, pat), evt_latch_o, (s == 1) && (pat != 0));
        irq_pend_i = '0;
        tick();
        drain();
        sev_on_pend_i = 1'b0;
      end
    end

    // R3 falling pend does not clear; R5 held pend does not re-set
    sev_on_pend_i = 1'b1;
    irq_pend_i = 3'b001; tick();
    check("R4 line0 rise", evt_latch_o, 1'b1);
    irq_pend_i = 3'b000; tick(); tick();
    check("R3 bit held after pend falls", evt_latch_o, 1'b1);
    irq_pend_i = 3'b100; tick();
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R5 cleared by WFE", evt_latch_o, 1'b0);
    repeat (4) tick();
    check("R5 held line no re-set", evt_latch_o, 1'b0);
    irq_pend_i = 3'b110; tick();
    check("R4 second line rise", evt_latch_o, 1'b1);
    irq_pend_i = '0; tick(); drain();
    sev_on_pend_i = 1'b0;

    // R8 WFI with pending lines returns at once
    for (int pat = 1; pat < (1 << N); pat++) begin
      irq_pend_i = pat[N-1:0];
      wfi_i = 1'b1; #1;
      check($sformatf("R8 wfi pend=%0d done", pat), hint_done_o, 1'b1);
      tick(); wfi_i = 1'b0;
      check($sformatf("R8 wfi pend=%0d no sleep", pat), sleep_req_o, 1'b0);
      irq_pend_i = '0; tick();
    end

    // R8 WFI sleep and wake on each line; event bit untouched
    for (int k = 0; k < N; k++) begin
      logic held;
      if (k == 0) pulse_sev();
      held = (k == 0);
      wfi_i = 1'b1; #1;
      check($sformatf("R8 wfi none k=%0d done", k), hint_done_o, 1'b0);
      tick(); wfi_i = 1'b0;
      check($sformatf("R8 wfi sleeps k=%0d", k), sleep_req_o, 1'b1);
      tick();
      check($sformatf("R8 wfi stays k=%0d", k), sleep_req_o, 1'b1);
      irq_pend_i = N'(1) << k; #1;
      check($sformatf("R8 wfi wake k=%0d", k), hint_done_o, 1'b1);
      tick();
      check($sformatf("R8 wfi sleep drops k=%0d", k), sleep_req_o, 1'b0);
      check($sformatf("R8 bit untouched k=%0d", k), evt_latch_o, held);
      irq_pend_i = '0; tick(); drain();
    end

    // R11 WFE and WFI together: WFE wins even with pending line
    irq_pend_i = 3'b010;
    wfe_i = 1'b1; wfi_i = 1'b1; #1;
    check("R11 WFE precedence no done", hint_done_o, 1'b0);
    tick(); wfe_i = 1'b0; wfi_i = 1'b0;
    check("R11 WFE precedence sleeps", sleep_req_o, 1'b1);
    pulse_sev(); #1;
    check("R7 wake by sev", hint_done_o, 1'b1);
    tick();
    check("R7 awake after sev", sleep_req_o, 1'b0);
    irq_pend_i = '0;
    tick();

    // R10 reset mid-sleep
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    sev_i = 1'b1; rst = 1'b1; tick(); sev_i = 1'b0; tick();
    rst = 1'b0; #1;
    check("R10 reset drops sleep", sleep_req_o, 1'b0);
    check("R10 reset clears bit", evt_latch_o, 1'b0);
    tick();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule